// File: doc/BRIEF.md
# Floating-Point Round-and-Pack Unit

This block is the last stage of a floating-point arithmetic pipe. It takes a result that has not yet been rounded and turns it into a packed value in the target format: a sign, a biased exponent, and a significand. The significand carries the hidden bit, the fraction and three extra low-order bits (guard, round, sticky). The unit applies one of five rounding modes. When the increment carries out of the significand, it renormalises. When the exponent is too large, it produces either infinity or the largest finite magnitude, depending on the mode and the sign. It raises inexact and overflow flags.

The format widths are parameters and default to a 15-bit exponent and a 112-bit fraction. The input is assumed to be normal: the hidden bit is 1 and the biased exponent is at least 1. Subnormal results and NaN inputs are handled upstream. A parameter adds one output register stage and is on by default, which gives one cycle of latency.

Top module: `round_pack_unit`

## Requirements
- R1: When the three discarded bits are all zero and the exponent fits, the output is the input sign, the low EXP_W exponent bits and the FRAC_W fraction bits unchanged under every mode, with both flags low.
- R2: Mode code 0 (nearest, ties to even) increments when the discarded bits exceed one half, or when they equal exactly one half and the retained LSB is 1.
- R3: Mode code 1 (toward zero) truncates the discarded bits. The unused codes 5, 6 and 7 behave exactly like code 1.
- R4: Mode code 3 (up) increments the magnitude of an inexact positive value only. Mode code 2 (down) increments the magnitude of an inexact negative value only.
- R5: Mode code 4 (to odd) truncates an inexact value and forces the retained fraction LSB to 1. An exact value is left unchanged.
- R6: When the increment carries out of the significand, the fraction becomes zero and the exponent rises by one.
- R7: If the rounded exponent reaches the all-ones code, mode 0, mode 3 with a positive sign and mode 2 with a negative sign give a signed infinity: exponent all ones, fraction zero.
- R8: On the same overflow, mode 1 (and codes 5 to 7), mode 3 with a negative sign, mode 2 with a positive sign and mode 4 give the signed largest finite value: exponent all ones minus one, fraction all ones.
- R9: The inexact flag is high when any discarded bit is nonzero or on overflow. The overflow flag is high exactly on overflow.
- R10: With the output register on, results and flags appear one clock after their inputs. Active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| inSign | input | 1 | Sign of the unrounded value |
| inExp | input | EXP_W+1 | Biased exponent, one spare high bit |
| inSig | input | FRAC_W+4 | Hidden bit, fraction, guard, round, sticky |
| rndMode | input | 3 | Rounding mode code |
| outVal | output | 1+EXP_W+FRAC_W | Packed result: sign, exponent, fraction |
| flagInexact | output | 1 | Result differs from the unrounded value |
| flagOverflow | output | 1 | Exponent exceeded the finite range |

## Verification
The embedded assertions check four things on every cycle: exact inputs pass through untouched and unflagged, to-odd results never become infinity and always end in a 1 when inexact, toward-zero results keep the truncated fraction, and overflow always implies inexact. The tie-to-even choice, the directed modes' dependence on sign, the carry-out renormalisation and the split between infinity and the largest finite value on overflow are shown only by the bench's scenarios. Those scenarios are compared against a behavioural model on every clock.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [2:0] {
    RM_NEAR = 3'd0,
    RM_ZERO = 3'd1,
    RM_DOWN = 3'd2,
    RM_UP   = 3'd3,
    RM_ODD  = 3'd4
  } rndMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic incEn;     // add one at the retained LSB
    logic ovfToInf;  // on overflow emit infinity, else largest finite
    logic inexact;   // some discarded bit is set
  } rndCtrl_t;
endpackage

// File: rtl/rp_ctrl.sv
module rp_ctrl
  import rp_pkg::*;
(
  input  logic       sign,
  input  logic [2:0] rndMode,
  input  logic       lsb,
  input  logic       grd,
  input  logic       rnd,
  input  logic       stk,
  output rndCtrl_t   ctrl
);
  rndMode_e modeSel;
  logic     anyTail;

  always_comb begin
    case (rndMode)
      3'd0:    modeSel = RM_NEAR;
      3'd2:    modeSel = RM_DOWN;
      3'd3:    modeSel = RM_UP;
      3'd4:    modeSel = RM_ODD;
      default: modeSel = RM_ZERO;
    endcase
  end

  assign anyTail = grd | rnd | stk;

  always_comb begin
    ctrl.inexact  = anyTail;
    ctrl.incEn    = 1'b0;
    ctrl.ovfToInf = 1'b0;
    unique case (modeSel)
      RM_NEAR: begin
        ctrl.incEn    = grd & (rnd | stk | lsb);
        ctrl.ovfToInf = 1'b1;
      end
      RM_DOWN: begin
        ctrl.incEn    = sign & anyTail;
        ctrl.ovfToInf = sign;
      end
      RM_UP: begin
        ctrl.incEn    = ~sign & anyTail;
        ctrl.ovfToInf = ~sign;
      end
      RM_ODD: begin
        // an even truncated value becomes odd by adding one; no carry possible
        ctrl.incEn    = ~lsb & anyTail;
        ctrl.ovfToInf = 1'b0;
      end
      default: begin
        ctrl.incEn    = 1'b0;
        ctrl.ovfToInf = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rp_datapath.sv
module rp_datapath
  import rp_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 112
) (
  input  logic                      sign,
  input  logic [EXP_W:0]            expIn,
  input  logic [FRAC_W:0]           keptSig,
  input  rndCtrl_t                  ctrl,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      overflow,
  output logic                      inexact
);
  localparam logic [EXP_W+1:0] EXP_ALL1 = {2'b00, {EXP_W{1'b1}}};
  localparam logic [EXP_W-1:0] EXP_MAXF = {{(EXP_W-1){1'b1}}, 1'b0};

  logic [FRAC_W+1:0] sumSig;
  logic              carryOut;
  logic [FRAC_W-1:0] fracNew;
  logic [EXP_W+1:0]  expNew;

  assign sumSig   = {1'b0, keptSig} + {{(FRAC_W+1){1'b0}}, ctrl.incEn};
  assign carryOut = sumSig[FRAC_W+1];
  // after a carry the significand is 10...0, so a shift leaves a zero fraction
  assign fracNew  = carryOut ? sumSig[FRAC_W:1] : sumSig[FRAC_W-1:0];
  assign expNew   = {1'b0, expIn} + {{(EXP_W+1){1'b0}}, carryOut};
  assign overflow = (expNew >= EXP_ALL1);
  assign inexact  = ctrl.inexact | overflow;

  always_comb begin
    if (!overflow)
      result = {sign, expNew[EXP_W-1:0], fracNew};
    else if (ctrl.ovfToInf)
      result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      result = {sign, EXP_MAXF, {FRAC_W{1'b1}}};
  end
endmodule

// File: rtl/round_pack_unit.sv
module round_pack_unit
  import rp_pkg::*;
#(
  parameter int EXP_W   = 15,
  parameter int FRAC_W  = 112,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inSign,
  input  logic [EXP_W:0]        inExp,
  input  logic [FRAC_W+3:0]     inSig,
  input  logic [2:0]            rndMode,
  output logic [EXP_W+FRAC_W:0] outVal,
  output logic                  flagInexact,
  output logic                  flagOverflow
);
  localparam int VAL_W = 1 + EXP_W + FRAC_W;

  rndCtrl_t         ctrlBus;
  logic [VAL_W-1:0] resComb;
  logic             ovfComb;
  logic             inexComb;

  rp_ctrl u_ctrl (
    .sign    (inSign),
    .rndMode (rndMode),
    .lsb     (inSig[3]),
    .grd     (inSig[2]),
    .rnd     (inSig[1]),
    .stk     (inSig[0]),
    .ctrl    (ctrlBus)
  );

  rp_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .sign     (inSign),
    .expIn    (inExp),
    .keptSig  (inSig[FRAC_W+3:3]),
    .ctrl     (ctrlBus),
    .result   (resComb),
    .overflow (ovfComb),
    .inexact  (inexComb)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          outVal       <= '0;
          flagInexact  <= 1'b0;
          flagOverflow <= 1'b0;
        end else begin
          outVal       <= resComb;
          flagInexact  <= inexComb;
          flagOverflow <= ovfComb;
        end
      end
    end else begin : g_comb
      assign outVal       = resComb;
      assign flagInexact  = inexComb;
      assign flagOverflow = ovfComb;
    end
  endgenerate

  // R1
  exact_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((inSig[2:0] == 3'b000) && !ovfComb) |->
      (resComb == {inSign, inExp[EXP_W-1:0], inSig[FRAC_W+2:3]}) && !inexComb);

  // R5
  odd_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rndMode == 3'd4) && (inSig[2:0] != 3'b000)) |-> resComb[0]);

  // R8
  odd_no_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rndMode == 3'd4) |-> (resComb[VAL_W-2 -: EXP_W] != {EXP_W{1'b1}}));

  // R3
  zero_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rndMode == 3'd1) && !ovfComb) |-> (resComb[FRAC_W-1:0] == inSig[FRAC_W+2:3]));

  // R9
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovfComb |-> inexComb);
endmodule

// File: tb/round_pack_unit_tb.sv
module round_pack_unit_tb;
  localparam int EW = 15;
  localparam int FW = 112;
  localparam int VW = 1 + EW + FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inSign = 1'b0;
  logic [EW:0]   inExp = '0;
  logic [FW+3:0] inSig = '0;
  logic [2:0]    rndMode = 3'd0;
  logic [VW-1:0] outVal;
  logic          flagInexact;
  logic          flagOverflow;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  round_pack_unit #(.EXP_W(EW), .FRAC_W(FW), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .inSign(inSign), .inExp(inExp), .inSig(inSig),
    .rndMode(rndMode), .outVal(outVal), .flagInexact(flagInexact),
    .flagOverflow(flagOverflow)
  );

  // behavioural reference: value of the discarded tail in eighths
  task automatic refModel(input logic s, input logic [EW:0] e, input logic [FW+3:0] sg,
                          input logic [2:0] m, output logic [VW-1:0] v,
                          output logic ix, output logic ov);
    logic [FW+1:0] mag;
    int            tail;
    int            ex;
    bit            bump;
    bit            toInf;
    mag  = {1'b0, sg[FW+3:3]};
    tail = int'(sg[2:0]);
    ex   = int'(e);
    bump = 0;
    case (m)
      3'd0: bump = (tail > 4) || (tail == 4 && mag[0]);
      3'd2: bump = s && tail != 0;
      3'd3: bump = !s && tail != 0;
      3'd4: bump = tail != 0 && !mag[0];
      default: bump = 0;
    endcase
    if (bump) mag = mag + 1;
    if (mag[FW+1]) begin
      mag = mag >> 1;
      ex  = ex + 1;
    end
    ix = (tail != 0);
    ov = 0;
    if (ex >= (1 << EW) - 1) begin
      ov = 1;
      ix = 1;
      toInf = (m == 3'd0) || (m == 3'd3 && !s) || (m == 3'd2 && s);
      if (toInf) v = {s, {EW{1'b1}}, {FW{1'b0}}};
      else       v = {s, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
    end else begin
      v = {s, ex[EW-1:0], mag[FW-1:0]};
    end
  endtask

  task automatic step(input logic s, input logic [EW:0] e, input logic [FW+3:0] sg,
                      input logic [2:0] m, input string tag);
    logic [VW-1:0] ev;
    logic          eix, eov;
    refModel(s, e, sg, m, ev, eix, eov);
    inSign = s; inExp = e; inSig = sg; rndMode = m;
    @(negedge clk);
    total++;
    if (outVal !== ev || flagInexact !== eix || flagOverflow !== eov) begin
      bad++;
      $display("FAIL %s: got val=%h ix=%b ov=%b expected val=%h ix=%b ov=%b",
               tag, outVal, flagInexact, flagOverflow, ev, eix, eov);
    end
  endtask

  function automatic logic [FW+3:0] mk(input logic [FW-1:0] f, input logic [2:0] t);
    return {1'b1, f, t};
  endfunction

  localparam logic [EW:0] EMAX = 16'h7FFE; // largest finite biased exponent

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (outVal !== '0 || flagInexact !== 1'b0 || flagOverflow !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset: got %h %b %b expected 0", outVal, flagInexact, flagOverflow);
    end
    rst_n = 1'b1;

    for (int m = 0; m < 8; m++) begin
      step(1'b0, 16'd100, mk(112'h1234, 3'b000), 3'(m), "R1 exact");
      step(1'b1, 16'd200, mk(112'h1235, 3'b000), 3'(m), "R1 exact neg");
    end
    // R10 latency: a one-cycle pulse of new inputs shows after one edge
    step(1'b0, 16'd5, mk(112'h7, 3'b101), 3'd0, "R10 latency");
    // R2 ties and above/below half
    step(1'b0, 16'd10, mk(112'h10, 3'b100), 3'd0, "R2 tie even");
    step(1'b0, 16'd10, mk(112'h11, 3'b100), 3'd0, "R2 tie odd");
    step(1'b0, 16'd10, mk(112'h10, 3'b101), 3'd0, "R2 above half");
    step(1'b0, 16'd10, mk(112'h11, 3'b011), 3'd0, "R2 below half");
    // R3 toward zero and unused codes
    for (int m = 5; m < 8; m++)
      step(1'b1, 16'd10, mk(112'h11, 3'b111), 3'(m), "R3 unused code");
    step(1'b0, 16'd10, mk(112'h11, 3'b111), 3'd1, "R3 toward zero");
    // R4 directed modes
    step(1'b0, 16'd10, mk(112'h20, 3'b001), 3'd3, "R4 up pos");
    step(1'b1, 16'd10, mk(112'h20, 3'b001), 3'd3, "R4 up neg");
    step(1'b0, 16'd10, mk(112'h20, 3'b001), 3'd2, "R4 down pos");
    step(1'b1, 16'd10, mk(112'h20, 3'b001), 3'd2, "R4 down neg");
    // R5 to odd
    step(1'b0, 16'd10, mk(112'h20, 3'b010), 3'd4, "R5 odd from even");
    step(1'b1, 16'd10, mk(112'h21, 3'b111), 3'd4, "R5 odd stays");
    step(1'b0, 16'd10, mk(112'h20, 3'b000), 3'd4, "R5 odd exact");
    // R6 carry out
    step(1'b0, 16'd10, mk({FW{1'b1}}, 3'b110), 3'd0, "R6 carry near");
    step(1'b1, 16'd10, mk({FW{1'b1}}, 3'b001), 3'd2, "R6 carry down");
    step(1'b0, 16'd10, mk({FW{1'b1}}, 3'b011), 3'd4, "R6 odd no carry");
    // R7 / R8 overflow through carry at top exponent
    for (int m = 0; m < 8; m++) begin
      step(1'b0, EMAX, mk({FW{1'b1}}, 3'b111), 3'(m), "R7 R8 carry ovf pos");
      step(1'b1, EMAX, mk({FW{1'b1}}, 3'b111), 3'(m), "R7 R8 carry ovf neg");
      step(1'b0, 16'h8005, mk(112'h3, 3'b000), 3'(m), "R7 R8 R9 big exp");
      step(1'b1, 16'h7FFF, mk(112'h2, 3'b000), 3'(m), "R7 R8 R9 exp all ones");
    end
    step(1'b0, EMAX, mk({FW{1'b1}}, 3'b000), 3'd0, "R1 max finite exact");
    // random mix covering R1..R9
    for (int i = 0; i < 3000; i++) begin
      logic [FW-1:0] f;
      logic [EW:0]   e;
      f = {$urandom, $urandom, $urandom, $urandom};
      if (i % 5 == 0) f = {FW{1'b1}};
      e = (i % 3 == 0) ? EMAX - 16'($urandom_range(0, 1)) : 16'($urandom_range(1, 32765));
      step(1'($urandom), e, mk(f, 3'($urandom)), 3'($urandom_range(0, 7)), "R9 random");
    end
    // R10 reset clears registered outputs
    step(1'b1, 16'd50, mk(112'h5, 3'b111), 3'd0, "R9 pre-reset");
    rst_n = 1'b0;
    #1;
    total++;
    if (outVal !== '0 || flagInexact !== 1'b0 || flagOverflow !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset clear: got %h %b %b expected 0", outVal, flagInexact, flagOverflow);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule